// File: doc/BRIEF.md
# Sparse-Connectivity Multiport Register File

This block is a bank of 256 three-bit storage entries built from flip-flops. Sixteen access ports work side by side, and every one of them can read or write in the same clock cycle. Each port carries an 8-bit address, a write enable, 3-bit write data, 3-bit read data and an error flag. The address is read as a point on a 16 by 16 grid. The upper nibble is the row and the lower nibble is the column.

A port is not wired to the whole bank. A compile-time mask of 256 bits per port lists the entries that port can reach. Read multiplexing and write decoding are built only for the entries whose mask bit is set. Each read path is therefore a narrow selector of a few tens of inputs instead of a full 256-way multiplexer.

Reads are combinational and show the contents from before any write in the same cycle. Writes land on the rising clock edge. When several ports write one entry together, the lowest-numbered port wins.

Top module: `rf_sparse_top`

## Requirements
- R1: While the active-low reset `rstN` is held low, every entry is cleared to 0. Right after reset, every in-mask read returns 0.
- R2: When a port's address lies inside its mask, its read data equals the current contents of the addressed entry. This holds for all 16 ports in the same cycle, with no clock latency.
- R3: When a port's address lies outside its mask, its read data is 0 and its error flag is 1. When the address lies inside the mask, the error flag is 0. The flag does not depend on the write enable.
- R4: A write with an in-mask address updates the entry at the next rising edge. In the cycle of the write, a read of that same entry still returns the old value.
- R5: A write with an out-of-mask address has no effect on any entry.
- R6: When two or more ports write the same entry with in-mask addresses in one cycle, the entry takes the data of the lowest-numbered of those ports.
- R7: With the default mask, port p reaches exactly the entries whose row (address bits 7:4) equals p or whose column (address bits 3:0) equals p. Port 0 therefore reaches row 0 and column 0, which is 31 entries. Port p sits at bits p*8+7:p*8 of `portAddr` and at bits p*3+2:p*3 of the data buses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes land on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| portAddr | input | 128 | Sixteen 8-bit addresses; port p at bits p*8+7:p*8 |
| portWe | input | 16 | Write enable, one bit per port |
| portWdata | input | 48 | Sixteen 3-bit write values |
| portRdata | output | 48 | Sixteen 3-bit read values |
| portErr | output | 16 | High when a port's address is outside its mask |

## Verification
Two things can fall in the same cycle: two ports writing one entry, which is settled by port priority, and a read of an entry that is being written, which must return the old value. Random addresses are mostly drawn from each port's own row or column. Entry (r,c) is reachable from both port r and port c, so same-entry writes from two ports happen often. Directed cycles also force a collision and a read of the entry being written. Each read and each error flag is compared with a bench model that applies writes from the highest port down to the lowest after every edge. Out-of-mask writes are then checked by reading the targeted entry through a port that can reach it.

// File: rtl/rf_sparse_pkg.sv
package rf_sparse_pkg;

  localparam int NUM_PORTS   = 16;
  localparam int NUM_ENTRIES = 256;
  localparam int DATA_W      = 3;
  localparam int ADDR_W      = 8;
  localparam int GRID_SIDE   = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_PORTS-1:0] wrGo;   // in-mask write request
    logic [NUM_PORTS-1:0] hit;    // address inside the port's mask
  } rfStrobe_t;

  // port p reaches row p and column p of the grid
  function automatic logic [NUM_PORTS*NUM_ENTRIES-1:0] defaultMask();
    logic [NUM_PORTS*NUM_ENTRIES-1:0] m;
    m = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if ((e / GRID_SIDE) == p || (e % GRID_SIDE) == p) m[p*NUM_ENTRIES + e] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/rf_sparse_ctrl.sv
module rf_sparse_ctrl
  import rf_sparse_pkg::*;
#(
  parameter int NP = NUM_PORTS,
  parameter int NE = NUM_ENTRIES,
  parameter int AW = ADDR_W,
  parameter logic [NUM_PORTS*NUM_ENTRIES-1:0] PORT_MASK = defaultMask()
) (
  input  logic [NP*AW-1:0] portAddr,
  input  logic [NP-1:0]    portWe,
  output rfStrobe_t        strobe,
  output logic [NP-1:0]    portErr
);

  logic [NP-1:0] hitVec;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      hitVec[p] = PORT_MASK[p*NE + int'(portAddr[p*AW +: AW])];
    end
  end

  assign strobe.hit  = hitVec;
  assign strobe.wrGo = portWe & hitVec;
  assign portErr     = ~hitVec;

endmodule

// File: rtl/rf_sparse_dp.sv
module rf_sparse_dp
  import rf_sparse_pkg::*;
#(
  parameter int NP = NUM_PORTS,
  parameter int NE = NUM_ENTRIES,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter logic [NUM_PORTS*NUM_ENTRIES-1:0] PORT_MASK = defaultMask()
) (
  input  logic             clk,
  input  logic             rstN,
  input  rfStrobe_t        strobe,
  input  logic [NP*AW-1:0] portAddr,
  input  logic [NP*DW-1:0] portWdata,
  output logic [NP*DW-1:0] portRdata,
  output logic [NE*DW-1:0] entryFlat
);

  logic [DW-1:0] store [NE];

  // write side: one update mux per entry, only masked ports feed it
  for (genvar e = 0; e < NE; e++) begin : g_entry
    logic [DW-1:0] nextVal;
    always_comb begin
      nextVal = store[e];
      // scan high to low so the lowest port writes last and wins
      for (int p = NP - 1; p >= 0; p--) begin
        if (PORT_MASK[p*NE + e] && strobe.wrGo[p] &&
            portAddr[p*AW +: AW] == AW'(e)) begin
          nextVal = portWdata[p*DW +: DW];
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) store[e] <= '0;
      else       store[e] <= nextVal;
    end

    assign entryFlat[e*DW +: DW] = store[e];
  end

  // read side: narrow OR-mux per port built from masked entries only
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [DW-1:0] term [NE];
    logic [DW-1:0] acc;
    for (genvar e = 0; e < NE; e++) begin : g_tap
      if (PORT_MASK[p*NE + e]) begin : g_on
        assign term[e] = (portAddr[p*AW +: AW] == AW'(e)) ? store[e] : '0;
      end else begin : g_off
        assign term[e] = '0;
      end
    end
    always_comb begin
      acc = '0;
      for (int e = 0; e < NE; e++) acc = acc | term[e];
    end
    assign portRdata[p*DW +: DW] = strobe.hit[p] ? acc : '0;
  end

endmodule

// File: rtl/rf_sparse_top.sv
module rf_sparse_top
  import rf_sparse_pkg::*;
#(
  parameter int NP = NUM_PORTS,
  parameter int NE = NUM_ENTRIES,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter logic [NUM_PORTS*NUM_ENTRIES-1:0] PORT_MASK = defaultMask()
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NP*AW-1:0] portAddr,
  input  logic [NP-1:0]    portWe,
  input  logic [NP*DW-1:0] portWdata,
  output logic [NP*DW-1:0] portRdata,
  output logic [NP-1:0]    portErr
);

  rfStrobe_t         strobe;
  logic [NE*DW-1:0]  entryFlat;

  rf_sparse_ctrl #(.NP(NP), .NE(NE), .AW(AW), .PORT_MASK(PORT_MASK)) u_ctrl (
    .portAddr (portAddr),
    .portWe   (portWe),
    .strobe   (strobe),
    .portErr  (portErr)
  );

  rf_sparse_dp #(.NP(NP), .NE(NE), .DW(DW), .AW(AW), .PORT_MASK(PORT_MASK)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .portAddr  (portAddr),
    .portWdata (portWdata),
    .portRdata (portRdata),
    .entryFlat (entryFlat)
  );

endmodule

// File: rtl/rf_sparse_chk.sv
module rf_sparse_chk
  import rf_sparse_pkg::*;
#(
  parameter int NP = NUM_PORTS,
  parameter int NE = NUM_ENTRIES,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input logic             clk,
  input logic             rstN,
  input logic [NP*AW-1:0] portAddr,
  input logic [NP-1:0]    portWe,
  input logic [NP*DW-1:0] portWdata,
  input logic [NP*DW-1:0] portRdata,
  input logic [NP-1:0]    portErr,
  input logic [NE*DW-1:0] entryFlat
);

  logic [NP-1:0] winVec;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      winVec[p] = portWe[p] && !portErr[p];
      for (int q = 0; q < p; q++) begin
        if (portWe[q] && !portErr[q] && portAddr[q*AW +: AW] == portAddr[p*AW +: AW])
          winVec[p] = 1'b0;
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R3
    err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      portErr[p] |-> portRdata[p*DW +: DW] == '0);

    // R2
    rd_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      !portErr[p] |-> portRdata[p*DW +: DW] == entryFlat[int'(portAddr[p*AW +: AW])*DW +: DW]);

    // R6
    win_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      winVec[p] |=> entryFlat[int'($past(portAddr[p*AW +: AW]))*DW +: DW] == $past(portWdata[p*DW +: DW]));
  end

  // R5
  no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((portWe & ~portErr) == '0) |=> $stable(entryFlat));

endmodule

bind rf_sparse_top rf_sparse_chk #(.NP(NP), .NE(NE), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .portAddr  (portAddr),
  .portWe    (portWe),
  .portWdata (portWdata),
  .portRdata (portRdata),
  .portErr   (portErr),
  .entryFlat (entryFlat)
);

// File: tb/rf_sparse_top_tb.sv
module rf_sparse_top_tb;

  localparam int NP = 16;
  localparam int NE = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [127:0]  portAddr = '0;
  logic [15:0]   portWe = '0;
  logic [47:0]   portWdata = '0;
  logic [47:0]   portRdata;
  logic [15:0]   portErr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [2:0] model [NE];

  always #10 clk = ~clk;  // 50 MHz

  rf_sparse_top u_dut (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .portWe(portWe),
    .portWdata(portWdata), .portRdata(portRdata), .portErr(portErr)
  );

  // R7: port p reaches row p or column p
  function automatic bit reach(int p, int a);
    return ((a >> 4) == p) || ((a & 15) == p);
  endfunction

  function automatic logic [2:0] expRead(int p, int a);
    return reach(p, a) ? model[a] : 3'd0;
  endfunction

  task automatic setPort(int p, int a, bit we, int d);
    portAddr[p*8 +: 8] = 8'(a);
    portWe[p]          = we;
    portWdata[p*3 +: 3] = 3'(d);
  endtask

  task automatic clearPorts();
    portAddr = '0; portWe = '0; portWdata = '0;
  endtask

  // compare every port's read and flag against the model (pre-write contents)
  task automatic checkReads(string tag);
    for (int p = 0; p < NP; p++) begin
      int a = int'(portAddr[p*8 +: 8]);
      checks++;
      if (portRdata[p*3 +: 3] !== expRead(p, a)) begin
        failures++;
        $display("FAIL %s rdata port=%0d addr=%0h actual=%0d expected=%0d",
                 tag, p, a, portRdata[p*3 +: 3], expRead(p, a));
      end
      checks++;
      if (portErr[p] !== !reach(p, a)) begin
        failures++;
        $display("FAIL R3 err port=%0d addr=%0h actual=%0b expected=%0b",
                 p, a, portErr[p], !reach(p, a));
      end
    end
  endtask

  // apply writes of the current cycle to the model, lowest port last (R4 R5 R6)
  task automatic modelWrite();
    for (int p = NP - 1; p >= 0; p--) begin
      int a = int'(portAddr[p*8 +: 8]);
      if (portWe[p] && reach(p, a)) model[a] = portWdata[p*3 +: 3];
    end
  endtask

  task automatic cycle(string tag);
    #2;
    checkReads(tag);
    @(posedge clk);
    modelWrite();
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED1234);
    for (int e = 0; e < NE; e++) model[e] = 3'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: after reset, each port reads its row entries as zero
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < NP; p++) setPort(p, (p << 4) | c, 0, 0);
      cycle("R1");
    end

    // R7: port 0 reaches row 0 and column 0 only; port 0 probes a few points
    clearPorts();
    setPort(0, 8'h07, 0, 0); setPort(1, 8'h71, 0, 0); setPort(2, 8'h33, 0, 0);
    setPort(3, 8'h44, 0, 0);
    cycle("R7");

    // R4: write then read-old in same cycle, new value next cycle
    clearPorts();
    setPort(4, 8'h4A, 1, 5);   // port 4 writes entry 0x4A
    setPort(10, 8'h4A, 0, 0);  // port 10 reads it in the same cycle: old value
    cycle("R4");
    setPort(4, 8'h4A, 0, 0);
    cycle("R4");

    // R6: ports 1 and 5 collide on 0x15; port 1 must win
    clearPorts();
    setPort(1, 8'h15, 1, 3);
    setPort(5, 8'h15, 1, 6);
    cycle("R6");
    clearPorts();
    setPort(5, 8'h15, 0, 0);
    cycle("R6");
    checks++;
    if (model[8'h15] !== 3'd3) begin
      failures++;
      $display("FAIL R6 model actual=%0d expected=3", model[8'h15]);
    end

    // R5: port 2 writes 0x35 (outside its mask); port 3 reads it after
    clearPorts();
    setPort(3, 8'h35, 1, 2);
    cycle("R5");
    clearPorts();
    setPort(2, 8'h35, 1, 7);
    cycle("R5");
    clearPorts();
    setPort(3, 8'h35, 0, 0);
    setPort(5, 8'h35, 0, 0);
    cycle("R5");

    // R2 R3 R4 R5 R6: constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NP; p++) begin
        int a;
        int r = int'($urandom % 16);
        case ($urandom % 5)
          0: a = int'($urandom % 256);
          1, 2: a = (p << 4) | r;
          default: a = (r << 4) | p;
        endcase
        setPort(p, a, bit'($urandom % 2), int'($urandom % 8));
      end
      cycle("R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule